// File: doc/BRIEF.md
# Slope-Compensated Current-Mode PWM Controller

This block drives the gate signal of a switching power converter under cycle-by-cycle current control. It works with an external analog comparator and an external DAC. The block sends a reference code to the DAC and reads back a single digital comparator result. While the switch is on, the reference code follows a compensation ramp. The ramp is set by three values: a start code, a step size and the number of clocks per step. It runs upward or downward and stops at the ends of the code range. A blanking window at the start of each on phase masks the comparator, so the spike at switch-on cannot end the pulse early.

The block has two modes. In fixed-frequency mode, a period pulse from an external timer turns the output on. A peak-current trip after blanking turns it off. In combined mode, one comparator does two jobs. While the switch is on, the block compares against the ramped peak reference. While the switch is off, it swaps the DAC code to a static zero-crossing threshold, and the next turn-on happens when the current falls below that threshold. In both modes a minimum-period clamp limits the switching frequency, and a maximum on-time forces turn-off if no trip arrives. An output flag records which event ended the last on phase. All settings are captured into shadow copies at each turn-on, so a setting written mid-cycle takes effect at the next cycle.

Top module: `slope_pwm_ctrl`

## Requirements
- R1: After reset, pwm_o is 0, end_cause_o is 0, all shadow settings are 0, the ramp code is 0, and the clocks-since-turn-on counter sits at its maximum, so the first turn-on is not held back by the clamp.
- R2: At turn-on the ramp code is loaded with cfg_init_i. While pwm_o is 1, the code moves by the step size once every cfg_div_i clocks, with cfg_div_i = 0 treated as 1. The code rises when cfg_dir_i = 1 and falls when cfg_dir_i = 0. The first move comes cfg_div_i clocks after turn-on, and the code holds while pwm_o is 0.
- R3: For the first cfg_blank_i clocks of an on phase, cmp_i is ignored. A trip held from turn-on therefore gives an on phase of exactly blank+1 clocks.
- R4: In fixed-frequency mode (mode_i = 0), a period_pulse_i while pwm_o is 0 and the clamp allows it sets pwm_o on the next clock. A period_pulse_i while pwm_o is 1 has no effect.
- R5: In combined mode (mode_i = 1), while pwm_o is 0, dac_o shows the zero-crossing code and sel_zcd_o is 1. cmp_i = 0 during that time counts as a zero crossing and triggers turn-on.
- R6: The ramp code saturates at 0 and at 2^DAC_W-1 instead of wrapping.
- R7: A turn-on occurs only when at least minper clocks have passed since the previous turn-on. The rising edges of pwm_o are then at least minper clocks apart.
- R8: pwm_o stays high for at most maxon clocks. A forced end sets end_cause_o to 1 and a peak trip sets it to 0. If both happen in the same clock, the trip wins.
- R9: All settings except mode_i are captured only at turn-on. A change made during a cycle has no effect until the next turn-on.
- R10: When mode_i = 0, or while pwm_o is 1, dac_o shows the ramp code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_i | input | 1 | 0 fixed-frequency peak mode, 1 combined peak/zero-crossing mode |
| period_pulse_i | input | 1 | Timer period pulse (fixed-frequency turn-on) |
| cmp_i | input | 1 | Comparator result, 1 = sensed current above DAC reference |
| cfg_dir_i | input | 1 | Ramp direction, 1 up, 0 down |
| cfg_init_i | input | DAC_W | Ramp start code |
| cfg_step_i | input | DAC_W | Ramp step size |
| cfg_div_i | input | CNT_W | Clocks per ramp step (0 acts as 1) |
| cfg_blank_i | input | CNT_W | Blanking length in clocks |
| cfg_maxon_i | input | CNT_W | Maximum on-time in clocks |
| cfg_minper_i | input | CNT_W | Minimum period in clocks |
| cfg_zcd_i | input | DAC_W | Zero-crossing threshold code |
| pwm_o | output | 1 | Gate drive |
| dac_o | output | DAC_W | Reference code to the DAC |
| sel_zcd_o | output | 1 | 1 while the zero-crossing code is selected |
| end_cause_o | output | 1 | 0 last on phase ended by trip, 1 by max on-time |

## Verification
The bench builds the block with DAC_W = 10 and CNT_W = 8. This keeps the full 10-bit code range, so both ramp saturation ends can be reached within one short on phase. It also means the clocks-since-turn-on counter saturates after 255 clocks, so the clamp, blanking and max-on limits can all be reached quickly. Scenarios cover a trip held through blanking, a tie between trip and max-on, ignored mid-pulse period pulses, and a combined-mode run in which the clamp rather than the zero crossing sets the period. They also include a mid-cycle setting change that must wait for the next turn-on.

// File: rtl/spwm_pkg.sv
package spwm_pkg;
  typedef enum logic {
    END_PEAK  = 1'b0,
    END_MAXON = 1'b1
  } end_cause_e;
endpackage

// File: rtl/spwm_ramp.sv
module spwm_ramp #(
  parameter int DAC_W = 10,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_i,
  input  logic             run_i,
  input  logic [DAC_W-1:0] init_i,
  input  logic [DAC_W-1:0] step_i,
  input  logic [CNT_W-1:0] div_i,
  input  logic             up_i,
  output logic [DAC_W-1:0] code_o,
  output logic             step_evt_o
);
  logic [CNT_W-1:0] sub_q;
  logic [CNT_W-1:0] last_sub;

  // saturating move of the code by one step
  function automatic logic [DAC_W-1:0] sat_move(input logic [DAC_W-1:0] c,
                                                input logic [DAC_W-1:0] s,
                                                input logic up);
    logic [DAC_W:0] sum;
    if (up) begin
      sum = {1'b0, c} + {1'b0, s};
      return sum[DAC_W] ? {DAC_W{1'b1}} : sum[DAC_W-1:0];
    end
    return (s > c) ? '0 : (c - s);
  endfunction

  assign last_sub   = (div_i == '0) ? '0 : (div_i - CNT_W'(1));
  assign step_evt_o = run_i && !start_i && (sub_q == last_sub);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      code_o <= '0;
      sub_q  <= '0;
    end else if (start_i) begin
      code_o <= init_i;
      sub_q  <= '0;
    end else if (run_i) begin
      if (step_evt_o) begin
        code_o <= sat_move(code_o, step_i, up_i);
        sub_q  <= '0;
      end else begin
        sub_q <= sub_q + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/spwm_phase.sv
module spwm_phase
  import spwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic             pulse_i,
  input  logic             cmp_i,
  input  logic [CNT_W-1:0] blank_i,
  input  logic [CNT_W-1:0] maxon_i,
  input  logic [CNT_W-1:0] minper_i,
  output logic             on_o,
  output logic             ton_o,
  output logic             trip_o,
  output logic             force_off_o,
  output logic             blanked_o,
  output logic             per_ok_o,
  output logic             cause_o,
  output logic [CNT_W-1:0] per_cnt_o
);
  localparam int CW1 = CNT_W + 1;

  end_cause_e   cause_q;
  logic [CW1-1:0] per_next;

  // clocks elapsed including the current one
  function automatic logic [CW1-1:0] elapsed(input logic [CNT_W-1:0] p);
    return {1'b0, p} + CW1'(1);
  endfunction

  assign per_next    = elapsed(per_cnt_o);
  assign per_ok_o    = per_next >= {1'b0, minper_i};
  assign ton_o       = !on_o && per_ok_o && (mode_i ? !cmp_i : pulse_i);
  assign blanked_o   = on_o && (per_cnt_o < blank_i);
  assign trip_o      = on_o && !blanked_o && cmp_i;
  assign force_off_o = on_o && !trip_o && (per_next >= {1'b0, maxon_i});
  assign cause_o     = cause_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      on_o      <= 1'b0;
      per_cnt_o <= '1;
      cause_q   <= END_PEAK;
    end else if (ton_o) begin
      on_o      <= 1'b1;
      per_cnt_o <= '0;
    end else begin
      if (per_cnt_o != '1) per_cnt_o <= per_cnt_o + CNT_W'(1);
      if (trip_o) begin
        on_o    <= 1'b0;
        cause_q <= END_PEAK;
      end else if (force_off_o) begin
        on_o    <= 1'b0;
        cause_q <= END_MAXON;
      end
    end
  end
endmodule

// File: rtl/slope_pwm_ctrl.sv
module slope_pwm_ctrl #(
  parameter int DAC_W = 10,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             mode_i,
  input  logic             period_pulse_i,
  input  logic             cmp_i,
  input  logic             cfg_dir_i,
  input  logic [DAC_W-1:0] cfg_init_i,
  input  logic [DAC_W-1:0] cfg_step_i,
  input  logic [CNT_W-1:0] cfg_div_i,
  input  logic [CNT_W-1:0] cfg_blank_i,
  input  logic [CNT_W-1:0] cfg_maxon_i,
  input  logic [CNT_W-1:0] cfg_minper_i,
  input  logic [DAC_W-1:0] cfg_zcd_i,
  output logic             pwm_o,
  output logic [DAC_W-1:0] dac_o,
  output logic             sel_zcd_o,
  output logic             end_cause_o
);
  // shadow copies, captured at turn-on
  logic             dir_s;
  logic [DAC_W-1:0] step_s, zcd_s;
  logic [CNT_W-1:0] div_s, blank_s, maxon_s, minper_s;

  // named internal events
  logic             on, ton, trip, force_off, blanked, per_ok, step_evt;
  logic [CNT_W-1:0] per_cnt;
  logic [DAC_W-1:0] ramp_code;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      dir_s    <= 1'b0;
      step_s   <= '0;
      zcd_s    <= '0;
      div_s    <= '0;
      blank_s  <= '0;
      maxon_s  <= '0;
      minper_s <= '0;
    end else if (ton) begin
      dir_s    <= cfg_dir_i;
      step_s   <= cfg_step_i;
      zcd_s    <= cfg_zcd_i;
      div_s    <= cfg_div_i;
      blank_s  <= cfg_blank_i;
      maxon_s  <= cfg_maxon_i;
      minper_s <= cfg_minper_i;
    end
  end

  spwm_phase #(.CNT_W(CNT_W)) u_phase (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_i      (mode_i),
    .pulse_i     (period_pulse_i),
    .cmp_i       (cmp_i),
    .blank_i     (blank_s),
    .maxon_i     (maxon_s),
    .minper_i    (minper_s),
    .on_o        (on),
    .ton_o       (ton),
    .trip_o      (trip),
    .force_off_o (force_off),
    .blanked_o   (blanked),
    .per_ok_o    (per_ok),
    .cause_o     (end_cause_o),
    .per_cnt_o   (per_cnt)
  );

  spwm_ramp #(.DAC_W(DAC_W), .CNT_W(CNT_W)) u_ramp (
    .clk        (clk),
    .rst_n      (rst_n),
    .start_i    (ton),
    .run_i      (on),
    .init_i     (cfg_init_i),
    .step_i     (step_s),
    .div_i      (div_s),
    .up_i       (dir_s),
    .code_o     (ramp_code),
    .step_evt_o (step_evt)
  );

  assign pwm_o     = on;
  assign sel_zcd_o = mode_i && !on;
  assign dac_o     = sel_zcd_o ? zcd_s : ramp_code;
endmodule

// File: rtl/spwm_chk.sv
module spwm_chk #(
  parameter int DAC_W = 10,
  parameter int CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwm_o,
  input logic             end_cause_o,
  input logic             cmp_i,
  input logic             ton,
  input logic             trip,
  input logic             force_off,
  input logic             blanked,
  input logic             step_evt,
  input logic             dir_s,
  input logic [CNT_W-1:0] per_cnt,
  input logic [CNT_W-1:0] maxon_s,
  input logic [CNT_W-1:0] minper_s,
  input logic [CNT_W-1:0] blank_s,
  input logic [DAC_W-1:0] cfg_init_i,
  input logic [DAC_W-1:0] ramp_code
);
  // R2
  ramp_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ton |=> (ramp_code == $past(cfg_init_i)) && pwm_o && (per_cnt == '0));

  // R3
  blank_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_o && blanked && cmp_i && !force_off) |=> pwm_o);

  // R6
  ramp_up_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && dir_s) |=> ramp_code >= $past(ramp_code));

  // R6
  ramp_dn_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !dir_s) |=> ramp_code <= $past(ramp_code));

  // R7
  min_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ton |-> ({1'b0, per_cnt} + 1'b1) >= {1'b0, minper_s});

  // R8
  trip_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    trip |=> !pwm_o && !end_cause_o);

  // R8
  maxon_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_o && !ton) |-> ({1'b0, per_cnt} < {1'b0, maxon_s}) || (maxon_s == '0));

  // R9
  shadow_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ton |=> $stable(maxon_s) && $stable(blank_s) && $stable(minper_s));
endmodule

bind slope_pwm_ctrl spwm_chk #(.DAC_W(DAC_W), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .pwm_o       (pwm_o),
  .end_cause_o (end_cause_o),
  .cmp_i       (cmp_i),
  .ton         (ton),
  .trip        (trip),
  .force_off   (force_off),
  .blanked     (blanked),
  .step_evt    (step_evt),
  .dir_s       (dir_s),
  .per_cnt     (per_cnt),
  .maxon_s     (maxon_s),
  .minper_s    (minper_s),
  .blank_s     (blank_s),
  .cfg_init_i  (cfg_init_i),
  .ramp_code   (ramp_code)
);

// File: tb/sim_slope_pwm_ctrl.sv
module sim_slope_pwm_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 10;
  localparam int CW = 8;
  localparam int CMAX = (1 << DW) - 1;
  localparam int PMAX = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, mode = 0, pulse = 0, cmp = 0, dir = 0;
  logic [DW-1:0] init = 0, step = 0, zcd = 0;
  logic [CW-1:0] div = 0, blank = 0, maxon = 0, minper = 0;
  logic pwm, sel, cause;
  logic [DW-1:0] dac;

  always #(CLK_PERIOD/2) clk = ~clk;

  slope_pwm_ctrl #(.DAC_W(DW), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode), .period_pulse_i(pulse), .cmp_i(cmp),
    .cfg_dir_i(dir), .cfg_init_i(init), .cfg_step_i(step), .cfg_div_i(div),
    .cfg_blank_i(blank), .cfg_maxon_i(maxon), .cfg_minper_i(minper), .cfg_zcd_i(zcd),
    .pwm_o(pwm), .dac_o(dac), .sel_zcd_o(sel), .end_cause_o(cause)
  );

  // behavioural reference model
  int m_on, m_per, m_ramp, m_sub, m_cause;
  int s_dir, s_step, s_zcd, s_div, s_blank, s_maxon, s_minper;
  int vecs = 0, miss = 0, cycles = 0;
  string cur_req = "R1";
  bit done = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_on = 0; m_per = PMAX; m_ramp = 0; m_sub = 0; m_cause = 0;
      s_dir = 0; s_step = 0; s_zcd = 0; s_div = 0; s_blank = 0; s_maxon = 0; s_minper = 0;
    end else begin
      bit go, trp, frc;
      int every;
      go  = !m_on && (m_per + 1 >= s_minper) && (mode ? !cmp : pulse);
      trp = m_on && (m_per >= s_blank) && cmp;
      frc = m_on && !trp && (m_per + 1 >= s_maxon);
      every = (s_div == 0) ? 1 : s_div;
      if (go) begin
        m_ramp = init; m_sub = 0;
      end else if (m_on) begin
        if (m_sub == every - 1) begin
          m_sub = 0;
          if (s_dir) m_ramp = (m_ramp + s_step > CMAX) ? CMAX : m_ramp + s_step;
          else       m_ramp = (m_ramp < s_step) ? 0 : m_ramp - s_step;
        end else m_sub++;
      end
      if (go) begin
        m_on = 1; m_per = 0;
        s_dir = dir; s_step = step; s_zcd = zcd; s_div = div;
        s_blank = blank; s_maxon = maxon; s_minper = minper;
      end else begin
        if (m_per < PMAX) m_per++;
        if (trp) begin m_on = 0; m_cause = 0; end
        else if (frc) begin m_on = 0; m_cause = 1; end
      end
    end
  end

  // bench-side measurements
  int hi = 0, last_len = 0, gap = 0, rise_gap = 0;
  logic prev = 0;

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, miss);
    $finish;
  endtask

  task automatic chk(string req, int act, int exp);
    vecs++;
    if (act != exp) begin
      miss++;
      $display("FAIL %s: got %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc();
    int edac;
    @(posedge clk);
    @(negedge clk);
    edac = (mode && !m_on) ? s_zcd : m_ramp;
    vecs++;
    if (pwm !== m_on[0] || dac !== edac[DW-1:0] || sel !== (mode && !m_on) ||
        cause !== m_cause[0]) begin
      miss++;
      $display("FAIL %s: pwm/dac/sel/cause %0d/%0d/%0d/%0d expected %0d/%0d/%0d/%0d",
               cur_req, pwm, dac, sel, cause, m_on, edac, (mode && !m_on), m_cause);
    end
    gap++;
    if (pwm && !prev) begin rise_gap = gap; gap = 0; end
    if (pwm) hi++;
    if (prev && !pwm) begin last_len = hi; hi = 0; end
    prev = pwm;
  endtask

  task automatic wait_low();
    for (int i = 0; i < 400 && pwm; i++) cyc();
  endtask

  task automatic fire();
    pulse = 1; cyc(); pulse = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000 && !done) begin
      miss++;
      $display("FAIL watchdog: got timeout expected completion");
      summary();
    end
  end

  initial begin
    cmp = 1;
    repeat (3) cyc();
    // R1 reset state
    chk("R1", pwm, 0); chk("R1", dac, 0); chk("R1", cause, 0);
    rst_n = 1;
    cyc();

    // R3: trip held from turn-on, blank 3
    cur_req = "R3";
    blank = 3; maxon = 50; minper = 0; init = 500; step = 4; div = 2; dir = 1; zcd = 100;
    fire(); wait_low();
    chk("R3", last_len, 4);
    chk("R8", cause, 0);

    // R4: pulse during on ignored, max-on ends it
    cur_req = "R4";
    cmp = 0; maxon = 10;
    cyc(); cyc();
    fire(); cyc(); cyc(); cyc();
    fire(); wait_low();
    chk("R4", last_len, 10);
    chk("R8", cause, 1);

    // R6/R10: upward ramp saturates at full scale, held in fixed mode while off
    cur_req = "R6";
    init = 1000; step = 10; div = 2; dir = 1; maxon = 20;
    cyc();
    fire();
    chk("R2", dac, 1000);
    wait_low(); cyc();
    chk("R6", dac, CMAX);
    chk("R10", dac, CMAX);

    // R2: downward ramp, div 0 acts as 1, saturates at 0
    cur_req = "R2";
    init = 20; step = 7; div = 0; dir = 0; maxon = 10;
    cyc();
    fire();          chk("R2", dac, 20);
    cyc();           chk("R2", dac, 13);
    cyc();           chk("R2", dac, 6);
    wait_low();      chk("R6", dac, 0);

    // R5/R7: combined mode, zero crossing right after turn-off, clamp sets period
    cur_req = "R5";
    cmp = 1; mode = 1;
    blank = 2; maxon = 30; minper = 40; zcd = 77; init = 600; step = 1; div = 4; dir = 1;
    cyc();
    for (int i = 0; i < 150; i++) begin
      cmp = pwm ? (hi >= 5) : 1'b0;
      cyc();
    end
    chk("R7", rise_gap, 40);
    cmp = 1;
    wait_low(); cyc();
    chk("R5", sel, 1);
    chk("R5", dac, 77);

    // R9: mid-cycle change waits for the next turn-on
    cur_req = "R9";
    mode = 0; cmp = 0; blank = 0; maxon = 12; minper = 0;
    repeat (45) cyc();
    fire();
    maxon = 3;
    wait_low();
    chk("R9", last_len, 12);
    cyc();
    fire(); wait_low();
    chk("R9", last_len, 3);

    // R8: trip and max-on in the same clock, trip wins
    cur_req = "R8";
    blank = 5; maxon = 6; cmp = 1;
    cyc();
    fire(); wait_low();
    chk("R8", last_len, 6);
    chk("R8", cause, 0);
    repeat (3) cyc();

    done = 1;
    summary();
  end
endmodule